// File: doc/BRIEF.md
# PIN Verification Gate for a Serial Memory Card

This block decides whether a 1 KB serial-memory card may be written. It takes command words that an upstream parser has already split into a 6-bit control code, a 10-bit address and a data byte. It keeps an 8-bit attempt counter, a 2-byte stored PIN and two protect bits. It runs the fixed verification order: spend one attempt, match the low PIN byte, then match the high PIN byte. When the order completes with both bytes matching, it raises a sticky write enable toward the memory array and drops a status flag.

The counter, the PIN and the protect bits live in registers that a load port can overwrite in one cycle. This stands in for the non-volatile image that is fetched at power-up. A read filter sits on the array read path. While the card is locked it hides the PIN locations, and it always shows the live counter value. A power-on reset clears the unlock. A rising edge on the card reset line only restores the status flag.

Top module: `card_pin_gate`

## Requirements
- R1: A command is the control code `cmd_ctrl_i` = {S0..S5} together with the full address. Code 6'b010011 at address 0x3FD is a counter-bit write. Code 6'b101100 at 0x3FE compares the low PIN byte, and the same code at 0x3FF compares the high PIN byte. Code 6'b110001 is an update. Any other code never advances verification.
- R2: A counter-bit write is accepted only if its data clears exactly one bit of the counter that is currently 1 and sets no bit. If accepted, the counter takes the data. Otherwise the counter is unchanged and `err_o` is high in the cycle after the command.
- R3: While locked, every write other than an accepted counter-bit write is rejected. This covers updates and array writes. A rejected write pulses `err_o` and changes neither the counter nor the PIN.
- R4: `arr_we_o` rises in the cycle after the high-byte compare only when the commands were, back to back: an accepted counter-bit write, a matching low compare, then a matching high compare.
- R5: Any command that is not the next expected step resets the sequence, and so does a mismatch on either byte. Before the next attempt, a new counter bit must be written.
- R6: A counter of 0x00 allows no accepted counter-bit write, so verification cannot succeed.
- R7: While locked, reads of 0x3FE or 0x3FF return 0x00. Once unlocked they return the stored byte. A read of 0x3FD always returns the counter, and every other address passes `arr_rd_data_i` through.
- R8: Unlock is sticky until `rst_ni`. On success `status_o` goes from 1 to 0. A rising edge of `card_rst_i` sets it back to 1 and leaves `arr_we_o` high.
- R9: The counter is never restored on its own. Once unlocked, an update to 0x3FD writes any value to it, for example 0xFF.
- R10: Once unlocked, an update to 0x3FE or 0x3FF rewrites that PIN byte if its protect bit is 1. Protect bit 0 covers the low byte and bit 1 covers the high byte. If the protect bit is 0, the update is rejected with an `err_o` pulse.
- R11: `load_i` overwrites the PIN (high byte in bits 15:8), the counter and the protect bits in one cycle. While it is high, `cmd_ready_o` is low.
- R12: `rst_ni` low gives `arr_we_o` = 0, `status_o` = 1, `err_o` = 0 and an idle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| card_rst_i | input | 1 | Card reset line; a rising edge restores status |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted this cycle |
| cmd_ctrl_i | input | 6 | Control code {S0..S5} |
| cmd_addr_i | input | 10 | Command address |
| cmd_data_i | input | 8 | Command data byte |
| load_i | input | 1 | Load the register image |
| load_pin_i | input | 16 | PIN image, high byte in 15:8 |
| load_cnt_i | input | 8 | Counter image |
| load_prot_i | input | 2 | Protect image, bit 1 for the high byte |
| rd_addr_i | input | 10 | Read address |
| arr_rd_data_i | input | 8 | Data read from the array |
| rd_data_o | output | 8 | Filtered read data |
| arr_we_o | output | 1 | Array write/erase enable (unlocked) |
| status_o | output | 1 | Status flag; 0 after a successful check |
| err_o | output | 1 | One-cycle rejected-write pulse |

## Verification
The assertions assume that `load_i` is never high while a sequence is being checked. The unlock-cause property compares the high byte against the stored PIN as it was one cycle earlier, so the stored PIN must not be reloaded during the check. They also assume that `card_rst_i` is low when reset is released. The bench drives load only with `cmd_valid_i` low and between sequences, and it holds the card reset line low except for explicit pulses taken while the card is unlocked. The counter-bit sweep and the low-byte guess sweep stay inside these assumptions by reloading the image before each attempt.

// File: rtl/card_pin_pkg.sv
package card_pin_pkg;
  parameter int unsigned ADDR_W = 10;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned CTRL_W = 6;
  parameter int unsigned NPIN   = 2;

  localparam logic [ADDR_W-1:0] CNT_ADDR    = ADDR_W'(1021);
  localparam logic [ADDR_W-1:0] PIN_LO_ADDR = ADDR_W'(1022);
  localparam logic [ADDR_W-1:0] PIN_HI_ADDR = ADDR_W'(1023);

  // codes read left to right as S0..S5
  localparam logic [CTRL_W-1:0] OP_BIT_WR = 6'b010011;
  localparam logic [CTRL_W-1:0] OP_CMP    = 6'b101100;
  localparam logic [CTRL_W-1:0] OP_UPD    = 6'b110001;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BIT  = 2'd1,
    SEQ_LO   = 2'd2
  } seq_e;

  typedef struct packed {
    logic any;
    logic bit_wr;
    logic cmp_lo;
    logic cmp_hi;
    logic upd_cnt;
    logic upd_lo;
    logic upd_hi;
    logic wr_other;
  } cmd_kind_t;
endpackage

// File: rtl/card_pin_decode.sv
module card_pin_decode
  import card_pin_pkg::*;
(
  input  logic              valid_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_kind_t         kind_o
);
  logic is_bw, is_cmp, is_upd;
  logic at_cnt, at_lo, at_hi;

  always_comb begin
    is_bw  = (ctrl_i == OP_BIT_WR);
    is_cmp = (ctrl_i == OP_CMP);
    is_upd = (ctrl_i == OP_UPD);
    at_cnt = (addr_i == CNT_ADDR);
    at_lo  = (addr_i == PIN_LO_ADDR);
    at_hi  = (addr_i == PIN_HI_ADDR);

    kind_o          = '0;
    kind_o.any      = valid_i;
    kind_o.bit_wr   = valid_i & is_bw & at_cnt;
    kind_o.cmp_lo   = valid_i & is_cmp & at_lo;
    kind_o.cmp_hi   = valid_i & is_cmp & at_hi;
    kind_o.upd_cnt  = valid_i & is_upd & at_cnt;
    kind_o.upd_lo   = valid_i & is_upd & at_lo;
    kind_o.upd_hi   = valid_i & is_upd & at_hi;
    // array writes and counter-bit codes aimed at non-counter addresses
    kind_o.wr_other = valid_i & ((is_bw & ~at_cnt) | (is_upd & ~(at_cnt | at_lo | at_hi)));
  end
endmodule

// File: rtl/card_pin_store.sv
module card_pin_store
  import card_pin_pkg::*;
#(
  parameter logic [NPIN*DATA_W-1:0] PIN_INIT  = '1,
  parameter logic [DATA_W-1:0]      CNT_INIT  = '1,
  parameter logic [NPIN-1:0]        PROT_INIT = '1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [NPIN*DATA_W-1:0] load_pin_i,
  input  logic [DATA_W-1:0]      load_cnt_i,
  input  logic [NPIN-1:0]        load_prot_i,
  input  cmd_kind_t              kind_i,
  input  logic [DATA_W-1:0]      data_i,
  input  logic                   unlocked_i,
  output logic [NPIN*DATA_W-1:0] pin_o,
  output logic [DATA_W-1:0]      cnt_o,
  output logic [NPIN-1:0]        prot_o,
  output logic                   bit_ok_o,
  output logic                   reject_o
);
  logic [NPIN-1:0][DATA_W-1:0] pin_q;
  logic [DATA_W-1:0]           cnt_q;
  logic [NPIN-1:0]             prot_q;
  logic [DATA_W-1:0]           cleared, raised;
  logic [NPIN-1:0]             upd_pin;
  logic                        prot_block;

  always_comb begin
    cleared  = cnt_q & ~data_i;
    raised   = data_i & ~cnt_q;
    bit_ok_o = (raised == '0) && (cleared != '0) &&
               ((cleared & (cleared - DATA_W'(1))) == '0);
  end

  assign upd_pin = {kind_i.upd_hi, kind_i.upd_lo};

  always_comb begin
    prot_block = |(upd_pin & ~prot_q);
    reject_o   = (kind_i.bit_wr & ~bit_ok_o)
               | (~unlocked_i & (kind_i.upd_cnt | (|upd_pin) | kind_i.wr_other))
               | (unlocked_i & prot_block);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_INIT;
      prot_q <= PROT_INIT;
    end else if (load_i) begin
      cnt_q  <= load_cnt_i;
      prot_q <= load_prot_i;
    end else if (kind_i.bit_wr && bit_ok_o) begin
      cnt_q  <= data_i;
    end else if (kind_i.upd_cnt && unlocked_i) begin
      cnt_q  <= data_i;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        pin_q[g] <= PIN_INIT[g*DATA_W +: DATA_W];
      else if (load_i)
        pin_q[g] <= load_pin_i[g*DATA_W +: DATA_W];
      else if (upd_pin[g] && unlocked_i && prot_q[g])
        pin_q[g] <= data_i;
    end
  end

  assign pin_o  = pin_q;
  assign cnt_o  = cnt_q;
  assign prot_o = prot_q;
endmodule

// File: rtl/card_pin_seq.sv
module card_pin_seq
  import card_pin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_rst_i,
  input  cmd_kind_t         kind_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] pin_lo_i,
  input  logic [DATA_W-1:0] pin_hi_i,
  input  logic              bit_ok_i,
  output logic              unlocked_o,
  output logic              status_o
);
  seq_e seq_q, seq_d;
  logic unlock_evt;
  logic unlocked_q, status_q, crst_q;
  logic crst_rise;

  always_comb begin
    seq_d      = seq_q;
    unlock_evt = 1'b0;
    if (kind_i.any) begin
      seq_d = SEQ_IDLE;
      if (kind_i.bit_wr && bit_ok_i)
        seq_d = SEQ_BIT;
      else if (kind_i.cmp_lo && seq_q == SEQ_BIT && data_i == pin_lo_i)
        seq_d = SEQ_LO;
      else if (kind_i.cmp_hi && seq_q == SEQ_LO && data_i == pin_hi_i)
        unlock_evt = 1'b1;
    end
  end

  assign crst_rise = card_rst_i & ~crst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q      <= SEQ_IDLE;
      unlocked_q <= 1'b0;
      status_q   <= 1'b1;
      crst_q     <= 1'b1;
    end else begin
      seq_q  <= seq_d;
      crst_q <= card_rst_i;
      if (unlock_evt) unlocked_q <= 1'b1;
      // success takes precedence over a same-cycle reset-line edge
      if (unlock_evt)     status_q <= 1'b0;
      else if (crst_rise) status_q <= 1'b1;
    end
  end

  assign unlocked_o = unlocked_q;
  assign status_o   = status_q;
endmodule

// File: rtl/card_pin_gate.sv
module card_pin_gate
  import card_pin_pkg::*;
#(
  parameter logic [NPIN*DATA_W-1:0] PIN_INIT  = '1,
  parameter logic [DATA_W-1:0]      CNT_INIT  = '1,
  parameter logic [NPIN-1:0]        PROT_INIT = '1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   card_rst_i,
  input  logic                   cmd_valid_i,
  output logic                   cmd_ready_o,
  input  logic [CTRL_W-1:0]      cmd_ctrl_i,
  input  logic [ADDR_W-1:0]      cmd_addr_i,
  input  logic [DATA_W-1:0]      cmd_data_i,
  input  logic                   load_i,
  input  logic [NPIN*DATA_W-1:0] load_pin_i,
  input  logic [DATA_W-1:0]      load_cnt_i,
  input  logic [NPIN-1:0]        load_prot_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [DATA_W-1:0]      arr_rd_data_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   arr_we_o,
  output logic                   status_o,
  output logic                   err_o
);
  cmd_kind_t                kind;
  logic [NPIN*DATA_W-1:0]   pin_all;
  logic [DATA_W-1:0]        pin_lo_q, pin_hi_q, cnt_q;
  logic [NPIN-1:0]          prot_q;
  logic                     bit_ok, reject, unlocked, err_q;

  assign cmd_ready_o = ~load_i;

  card_pin_decode u_decode (
    .valid_i (cmd_valid_i & cmd_ready_o),
    .ctrl_i  (cmd_ctrl_i),
    .addr_i  (cmd_addr_i),
    .kind_o  (kind)
  );

  card_pin_store #(
    .PIN_INIT  (PIN_INIT),
    .CNT_INIT  (CNT_INIT),
    .PROT_INIT (PROT_INIT)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_pin_i  (load_pin_i),
    .load_cnt_i  (load_cnt_i),
    .load_prot_i (load_prot_i),
    .kind_i      (kind),
    .data_i      (cmd_data_i),
    .unlocked_i  (unlocked),
    .pin_o       (pin_all),
    .cnt_o       (cnt_q),
    .prot_o      (prot_q),
    .bit_ok_o    (bit_ok),
    .reject_o    (reject)
  );

  assign pin_lo_q = pin_all[DATA_W-1:0];
  assign pin_hi_q = pin_all[2*DATA_W-1:DATA_W];

  card_pin_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .card_rst_i (card_rst_i),
    .kind_i     (kind),
    .data_i     (cmd_data_i),
    .pin_lo_i   (pin_lo_q),
    .pin_hi_i   (pin_hi_q),
    .bit_ok_i   (bit_ok),
    .unlocked_o (unlocked),
    .status_o   (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= reject;
  end

  always_comb begin
    if (rd_addr_i == CNT_ADDR)
      rd_data_o = cnt_q;
    else if (rd_addr_i == PIN_LO_ADDR)
      rd_data_o = unlocked ? pin_lo_q : '0;
    else if (rd_addr_i == PIN_HI_ADDR)
      rd_data_o = unlocked ? pin_hi_q : '0;
    else
      rd_data_o = arr_rd_data_i;
  end

  assign arr_we_o = unlocked;
  assign err_o    = err_q;
endmodule

// File: rtl/card_pin_gate_chk.sv
module card_pin_gate_chk
  import card_pin_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [CTRL_W-1:0] cmd_ctrl_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic [DATA_W-1:0] cmd_data_i,
  input logic              load_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              arr_we_o,
  input logic              status_o,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] pin_lo_q,
  input logic [DATA_W-1:0] pin_hi_q,
  input logic [NPIN-1:0]   prot_q
);
  AST_LOCKED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arr_we_o && (rd_addr_i == PIN_LO_ADDR || rd_addr_i == PIN_HI_ADDR)) |-> rd_data_o == '0); // R7

  AST_UNLOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |=> arr_we_o); // R8

  AST_UNLOCK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arr_we_o) |-> $past(cmd_valid_i && !load_i && cmd_ctrl_i == OP_CMP &&
                              cmd_addr_i == PIN_HI_ADDR && cmd_data_i == pin_hi_q)); // R4

  AST_CNT_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q) && !$past(arr_we_o) && !$past(load_i)) |->
      ((cnt_q & ~$past(cnt_q)) == '0 && $countones($past(cnt_q) & ~cnt_q) == 1)); // R2

  AST_STATUS_FALL_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o) |-> arr_we_o); // R8

  AST_PIN_PROTECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && !$past(prot_q[0])) |-> $stable(pin_lo_q)); // R10

  AST_LOCKED_PIN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && !$past(arr_we_o)) |-> ($stable(pin_lo_q) && $stable(pin_hi_q))); // R3
endmodule

bind card_pin_gate card_pin_gate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ctrl_i  (cmd_ctrl_i),
  .cmd_addr_i  (cmd_addr_i),
  .cmd_data_i  (cmd_data_i),
  .load_i      (load_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .arr_we_o    (arr_we_o),
  .status_o    (status_o),
  .cnt_q       (cnt_q),
  .pin_lo_q    (pin_lo_q),
  .pin_hi_q    (pin_hi_q),
  .prot_q      (prot_q)
);

// File: tb/card_pin_gate_tb.sv
`timescale 1ns/1ps
module card_pin_gate_tb;
  import card_pin_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_rst = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_ctrl = '0;
  logic [9:0]  cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        load = 1'b0;
  logic [15:0] load_pin = '0;
  logic [7:0]  load_cnt = '0;
  logic [1:0]  load_prot = '0;
  logic [9:0]  rd_addr = '0;
  logic [7:0]  arr_data = 8'h77;
  logic [7:0]  rd_data;
  logic        arr_we, status, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [9:0] A_CNT = 10'h3FD;
  localparam logic [9:0] A_LO  = 10'h3FE;
  localparam logic [9:0] A_HI  = 10'h3FF;
  localparam logic [5:0] C_BW  = 6'b010011;
  localparam logic [5:0] C_CMP = 6'b101100;
  localparam logic [5:0] C_UPD = 6'b110001;

  always #2.5 clk = ~clk;

  card_pin_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .card_rst_i(card_rst),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_ctrl_i(cmd_ctrl),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .load_i(load), .load_pin_i(load_pin), .load_cnt_i(load_cnt), .load_prot_i(load_prot),
    .rd_addr_i(rd_addr), .arr_rd_data_i(arr_data), .rd_data_o(rd_data),
    .arr_we_o(arr_we), .status_o(status), .err_o(err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [5:0] c, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ctrl = c; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic ld(input logic [15:0] p, input logic [7:0] c, input logic [1:0] pr);
    @(negedge clk);
    load = 1'b1; load_pin = p; load_cnt = c; load_prot = pr;
    #1;
    chk("R11 ready low during load", {15'd0, cmd_ready}, 16'd0);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic por();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic attempt(input logic [7:0] bitv, input logic [7:0] lo, input logic [7:0] hi);
    cmd(C_BW, A_CNT, bitv);
    cmd(C_CMP, A_LO, lo);
    cmd(C_CMP, A_HI, hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] cv [4];
    cv[0] = 8'hFF; cv[1] = 8'hA5; cv[2] = 8'h01; cv[3] = 8'h00;

    repeat (3) @(negedge clk);
    chk("R12 reset we", {15'd0, arr_we}, 16'd0);
    chk("R12 reset status", {15'd0, status}, 16'd1);
    chk("R12 reset err", {15'd0, err}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 load and R7 read paths
    ld(16'h3C5A, 8'hFF, 2'b11);
    rd(A_CNT, v);  chk("R11 counter loaded", {8'd0, v}, 16'h00FF);
    rd(A_LO, v);   chk("R7 locked low read", {8'd0, v}, 16'h0000);
    rd(A_HI, v);   chk("R7 locked high read", {8'd0, v}, 16'h0000);
    rd(10'h010, v); chk("R7 array passthrough", {8'd0, v}, 16'h0077);

    // R2 / R6 sweep of every data byte against several counter values
    for (int ci = 0; ci < 4; ci++) begin
      for (int d = 0; d < 256; d++) begin
        int clr, set;
        logic ok;
        logic [7:0] c, dd, expc;
        c = cv[ci]; dd = 8'(d); clr = 0; set = 0;
        for (int b = 0; b < 8; b++) begin
          if (c[b] && !dd[b]) clr++;
          if (!c[b] && dd[b]) set++;
        end
        ok = (set == 0) && (clr == 1);
        expc = ok ? dd : c;
        ld(16'h3C5A, c, 2'b11);
        cmd(C_BW, A_CNT, dd);
        rd(A_CNT, v);
        chk(ci == 3 ? "R6 zero counter bit write" : "R2 counter bit write",
            {7'd0, err, v}, {7'd0, !ok, expc});
      end
    end

    // R6 zero counter blocks verification
    ld(16'h3C5A, 8'h00, 2'b11);
    attempt(8'h00, 8'h5A, 8'h3C);
    chk("R6 no unlock at zero", {15'd0, arr_we}, 16'd0);

    // R1 wrong control code does not advance
    ld(16'h3C5A, 8'hFF, 2'b11);
    cmd(C_BW, A_CNT, 8'hFE);
    cmd(6'b101101, A_LO, 8'h5A);
    cmd(C_CMP, A_HI, 8'h3C);
    chk("R1 bad code", {15'd0, arr_we}, 16'd0);
    cmd(C_CMP, 10'h1FE, 8'h5A);
    chk("R1 bad address", {15'd0, arr_we}, 16'd0);

    // R5 ordering violations
    ld(16'h3C5A, 8'hFF, 2'b11);
    cmd(C_CMP, A_LO, 8'h5A); cmd(C_CMP, A_HI, 8'h3C);
    chk("R5 no bit write", {15'd0, arr_we}, 16'd0);
    cmd(C_BW, A_CNT, 8'hFE); cmd(C_CMP, A_HI, 8'h3C);
    chk("R5 skipped low", {15'd0, arr_we}, 16'd0);
    cmd(C_BW, A_CNT, 8'hFC); cmd(C_CMP, A_LO, 8'h5A); cmd(C_CMP, A_LO, 8'h5A);
    cmd(C_CMP, A_HI, 8'h3C);
    chk("R5 repeated low", {15'd0, arr_we}, 16'd0);
    attempt(8'hF8, 8'h5A, 8'h3D);
    cmd(C_CMP, A_LO, 8'h5A); cmd(C_CMP, A_HI, 8'h3C);
    chk("R5 retry without new bit", {15'd0, arr_we}, 16'd0);
    rd(A_CNT, v); chk("R9 counter not restored", {8'd0, v}, 16'h00F8);

    // R3 locked writes rejected
    cmd(C_UPD, A_CNT, 8'hFF);
    chk("R3 locked counter update err", {15'd0, err}, 16'd1);
    rd(A_CNT, v); chk("R3 counter kept", {8'd0, v}, 16'h00F8);
    cmd(C_UPD, A_LO, 8'h00);
    chk("R3 locked pin update err", {15'd0, err}, 16'd1);
    cmd(C_UPD, 10'h100, 8'h12);
    chk("R3 locked array write err", {15'd0, err}, 16'd1);

    // R4 exhaustive low-byte guesses
    for (int g = 0; g < 256; g++) begin
      ld(16'h3C5A, 8'hFF, 2'b11);
      chk("R4 locked before attempt", {15'd0, arr_we}, 16'd0);
      attempt(8'hFE, 8'(g), 8'h3C);
      chk("R4 unlock only on match", {15'd0, arr_we}, {15'd0, g == 8'h5A});
      chk("R8 status after attempt", {15'd0, status}, {15'd0, g != 8'h5A});
      if (arr_we) begin
        rd(A_LO, v); chk("R3 pin intact after rejected update", {8'd0, v}, 16'h005A);
        rd(A_HI, v); chk("R7 unlocked high read", {8'd0, v}, 16'h003C);
        por();
      end
    end

    // unlock for post-unlock checks
    ld(16'h3C5A, 8'hFF, 2'b11);
    attempt(8'hBF, 8'h5A, 8'h3C);
    chk("R4 unlock", {15'd0, arr_we}, 16'd1);
    rd(A_CNT, v); chk("R9 counter kept after unlock", {8'd0, v}, 16'h00BF);

    // R8 card reset edge
    @(negedge clk); card_rst = 1'b1;
    @(negedge clk); card_rst = 1'b0;
    chk("R8 status restored", {15'd0, status}, 16'd1);
    repeat (4) @(negedge clk);
    chk("R8 unlock sticky", {15'd0, arr_we}, 16'd1);

    // R9 counter erase after unlock
    cmd(C_UPD, A_CNT, 8'hFF);
    chk("R9 erase no err", {15'd0, err}, 16'd0);
    rd(A_CNT, v); chk("R9 counter erased", {8'd0, v}, 16'h00FF);

    // R10 protected rewrite
    cmd(C_UPD, A_LO, 8'h11);
    rd(A_LO, v); chk("R10 low rewritten", {8'd0, v}, 16'h0011);
    ld(16'h3C11, 8'hFF, 2'b01);
    chk("R11 load keeps unlock", {15'd0, arr_we}, 16'd1);
    cmd(C_UPD, A_HI, 8'h99);
    chk("R10 protected err", {15'd0, err}, 16'd1);
    rd(A_HI, v); chk("R10 high protected", {8'd0, v}, 16'h003C);
    ld(16'h3C11, 8'hFF, 2'b10);
    cmd(C_UPD, A_LO, 8'h22);
    chk("R10 low protected err", {15'd0, err}, 16'd1);
    rd(A_LO, v); chk("R10 low protected", {8'd0, v}, 16'h0011);
    cmd(C_UPD, A_HI, 8'h44);
    rd(A_HI, v); chk("R10 high rewritten", {8'd0, v}, 16'h0044);

    // R12 power-on reset clears unlock
    por();
    chk("R12 we cleared", {15'd0, arr_we}, 16'd0);
    chk("R12 status set", {15'd0, status}, 16'd1);
    ld(16'h3C5A, 8'hFF, 2'b11);
    rd(A_LO, v); chk("R12 pin hidden again", {8'd0, v}, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule